// File: doc/BRIEF.md
# Complement-Pair Low-Latency Link Framer

This block carries payload words across a latency-critical serial path without line coding. The transmit half takes one payload word every second line-clock cycle, one bunch-clock tick. It puts that word on the line as two consecutive line words, first unchanged and then with every bit flipped. Every bit therefore toggles within each pair, so the line stays DC-balanced and has plenty of transitions for clock recovery, at a payload efficiency of one half. The word reaches the line one cycle after it is sampled, and no encoder stage sits in the path.

The receive half takes parallel line words from a deserializer that runs in the same clock domain. It compares each word with the one before it and counts complementary pairs separately for each slot parity, using a signed up/down counter. After eight consecutive good pairs at one parity, it locks and fixes which slot holds the true word. While locked it presents one payload word per tick at a fixed latency, flags any pair that fails the complement test, and drops lock after four consecutive failures. There is no elastic buffer, so the latency from line to payload is a single register stage after the inverted word arrives.

Top module: `cpl_link`

## Requirements
- R1: When `tx_take_o` is high at a clock edge, `tx_data_i` is sampled at that edge. `tx_line_o` then shows that word unchanged during the following cycle and its bitwise inverse during the cycle after that.
- R2: `tx_take_o` is high in the first cycle after reset and then on every second cycle.
- R3: Starting from reset, with a pair stream of changing payload words at either slot parity, `rx_lock_o` rises in the cycle that the eighth consecutive complementary pair completes at that parity. This holds for the stream as sent and for the same stream shifted by one line word.
- R4: A line held at one constant value never produces lock. A transmitter that repeats one fixed payload word never produces lock either, because both slot parities then look equally valid.
- R5: While locked, each pair whose second word is not the bitwise inverse of its first raises `rx_err_o` for exactly one cycle. Fewer than four consecutive failures leave `rx_lock_o` high. `rx_err_o` is never high unless lock was held in the cycle before.
- R6: The fourth consecutive failed pair clears `rx_lock_o` in the same cycle that its `rx_err_o` pulse appears. The receiver then searches again and relocks on a good stream.
- R7: While locked, `rx_valid_o` is high exactly once every two cycles. `rx_data_o` then holds the true-slot word, one cycle after the inverted word is taken from `rx_line_i`. On a direct loopback this is two cycles after `tx_take_o` sampled the word.
- R8: An all-zeros or all-ones payload word, and single-bit payload words, pass as valid pairs with no error pulse.
- R9: While unlocked, `rx_valid_o` is low and `rx_data_o` is zero.
- R10: While `rst_n` is low, `tx_take_o` is high and `tx_line_o`, `rx_data_o`, `rx_valid_o`, `rx_lock_o` and `rx_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-word clock, twice the payload rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_data_i | input | W | Payload word to transmit |
| tx_take_o | output | 1 | High when tx_data_i is sampled at this edge |
| tx_line_o | output | W | Line word to the serializer |
| rx_line_i | input | W | Line word from the deserializer |
| rx_data_o | output | W | Recovered payload word |
| rx_valid_o | output | 1 | One-cycle strobe per payload tick while locked |
| rx_lock_o | output | 1 | Receiver aligned to the pair boundary |
| rx_err_o | output | 1 | One-cycle pulse for a failed pair while locked |

## Verification
The receiver is fed four kinds of pattern, and each one separates a different kind of fault.
- A changing payload sequence on a direct loopback, and the same sequence delayed by one line word, show whether both slot parities are resolved and whether the payload latency is exact.
- Zero, all-ones and walking-one payloads show whether the complement test wrongly rejects degenerate words.
- Constant line segments five and seven words long always break exactly three and four pairs, whatever their alignment, which pins down the loss threshold. A single flipped bit gives exactly one error pulse.
- An idle constant line and a repeated fixed payload show that ambiguous inputs never produce a false lock.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

  // Receiver alignment state
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } rx_state_e;

endpackage

// File: rtl/cpl_tx.sv
module cpl_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_i,
  output logic         take_o,
  output logic [W-1:0] line_o
);

  logic         ph_q, ph_d;      // 0: true slot next, 1: inverted slot next
  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] line_q, line_d;

  always_comb begin
    ph_d   = ~ph_q;
    hold_d = hold_q;
    line_d = line_q;
    if (!ph_q) begin
      hold_d = data_i;
      line_d = data_i;
    end else begin
      line_d = ~hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      hold_q <= '0;
      line_q <= '0;
    end else begin
      ph_q   <= ph_d;
      hold_q <= hold_d;
      line_q <= line_d;
    end
  end

  assign take_o = ~ph_q;
  assign line_o = line_q;

endmodule

// File: rtl/cpl_align.sv
module cpl_align #(
  parameter  int LOCK_N = 8,
  localparam int CW     = $clog2(LOCK_N + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic search_i,
  input  logic ok_i,
  input  logic ph_i,
  output logic hit_o,
  output logic hit_ph_o
);

  localparam logic signed [CW-1:0] LIM  = CW'(LOCK_N);
  localparam logic signed [CW-1:0] ONE  = CW'(1);
  localparam logic signed [CW-1:0] ZERO = '0;

  // Positive count: pairs completing at parity 1; negative: parity 0
  logic signed [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!search_i) begin
      cnt_d = ZERO;
    end else if (ph_i) begin
      if (ok_i) begin
        if (cnt_q <= ZERO)     cnt_d = ONE;
        else if (cnt_q < LIM)  cnt_d = cnt_q + ONE;
      end else if (cnt_q > ZERO) begin
        cnt_d = ZERO;
      end
    end else begin
      if (ok_i) begin
        if (cnt_q >= ZERO)     cnt_d = -ONE;
        else if (cnt_q > -LIM) cnt_d = cnt_q - ONE;
      end else if (cnt_q < ZERO) begin
        cnt_d = ZERO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_d;
  end

  assign hit_o    = search_i && ((cnt_d == LIM) || (cnt_d == -LIM));
  assign hit_ph_o = ph_i;

endmodule

// File: rtl/cpl_rx.sv
module cpl_rx
  import cpl_pkg::*;
#(
  parameter  int W      = 16,
  parameter  int LOCK_N = 8,
  parameter  int LOSS_N = 4,
  localparam int EW     = $clog2(LOSS_N) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         lock_o,
  output logic         err_o
);

  rx_state_e    st_q, st_d;
  logic [W-1:0] prev_q, data_q, data_d;
  logic         ph_q, sel_q, sel_d;
  logic         valid_q, valid_d, err_q, err_d;
  logic [EW-1:0] errc_q, errc_d;
  logic         pair_ok, hit, hit_ph;

  assign pair_ok = (line_i == ~prev_q);

  cpl_align #(.LOCK_N(LOCK_N)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .search_i (st_q == ST_SEARCH),
    .ok_i     (pair_ok),
    .ph_i     (ph_q),
    .hit_o    (hit),
    .hit_ph_o (hit_ph)
  );

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    errc_d  = errc_q;
    data_d  = data_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    if (st_q == ST_SEARCH) begin
      data_d = '0;
      if (hit) begin
        st_d   = ST_LOCKED;
        sel_d  = hit_ph;
        errc_d = '0;
      end
    end else if (ph_q == sel_q) begin
      valid_d = 1'b1;
      data_d  = prev_q;
      if (pair_ok) begin
        errc_d = '0;
      end else begin
        err_d = 1'b1;
        if (errc_q == EW'(LOSS_N - 1)) begin
          st_d    = ST_SEARCH;
          errc_d  = '0;
          valid_d = 1'b0;
          data_d  = '0;
        end else begin
          errc_d = errc_q + EW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SEARCH;
      prev_q  <= '0;
      ph_q    <= 1'b0;
      sel_q   <= 1'b0;
      errc_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      prev_q  <= line_i;
      ph_q    <= ~ph_q;
      sel_q   <= sel_d;
      errc_q  <= errc_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign lock_o  = (st_q == ST_LOCKED);
  assign err_o   = err_q;

endmodule

// File: rtl/cpl_link.sv
module cpl_link #(
  parameter int W      = 16,
  parameter int LOCK_N = 8,
  parameter int LOSS_N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_take_o,
  output logic [W-1:0] tx_line_o,
  input  logic [W-1:0] rx_line_i,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o,
  output logic         rx_lock_o,
  output logic         rx_err_o
);

  cpl_tx #(.W(W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_i (tx_data_i),
    .take_o (tx_take_o),
    .line_o (tx_line_o)
  );

  cpl_rx #(.W(W), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (rx_line_i),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o),
    .lock_o  (rx_lock_o),
    .err_o   (rx_err_o)
  );

endmodule

// File: rtl/cpl_link_chk.sv
module cpl_link_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tx_data_i,
  input logic         tx_take_o,
  input logic [W-1:0] tx_line_o,
  input logic [W-1:0] rx_data_o,
  input logic         rx_valid_o,
  input logic         rx_lock_o,
  input logic         rx_err_o
);

  AST_TX_TRUE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |=> (tx_line_o == $past(tx_data_i)));                    // R1
  AST_TX_INV_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_take_o |=> (tx_line_o == ~$past(tx_line_o)));                  // R1
  AST_TAKE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |=> !tx_take_o);                                         // R2
  AST_TAKE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_take_o |=> tx_take_o);                                         // R2
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |=> !rx_err_o);                                           // R5
  AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> $past(rx_lock_o));                                    // R5
  AST_LOSS_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_lock_o) |-> rx_err_o);                                    // R6
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);                                       // R7
  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_lock_o |-> (!rx_valid_o && (rx_data_o == '0)));                // R9

endmodule

bind cpl_link cpl_link_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_data_i  (tx_data_i),
  .tx_take_o  (tx_take_o),
  .tx_line_o  (tx_line_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o),
  .rx_lock_o  (rx_lock_o),
  .rx_err_o   (rx_err_o)
);

// File: tb/cpl_link_tb.sv
module cpl_link_tb;

  localparam int W = 16;
  localparam int M = 1024;
  localparam logic [W-1:0] CVAL = 16'h5A5A;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data_i = '0;
  logic         tx_take_o;
  logic [W-1:0] tx_line_o;
  logic [W-1:0] rx_line_i = '0;
  logic [W-1:0] rx_data_o;
  logic         rx_valid_o, rx_lock_o, rx_err_o;

  cpl_link #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_data_i(tx_data_i), .tx_take_o(tx_take_o), .tx_line_o(tx_line_o),
    .rx_line_i(rx_line_i), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .rx_lock_o(rx_lock_o), .rx_err_o(rx_err_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model state
  logic [W-1:0] w [M];
  bit           took [M];
  int  n = 0, k = 0;
  int  gen_mode = 0;            // 0 sequence, 1 fixed, 2 special words
  bit  dly = 0, cmode = 0;
  logic [W-1:0] cword = CVAL;
  logic [W-1:0] mask = '0;
  logic [W-1:0] hold = '0, lastw = '0;
  int  pairs = 0, errs = 0, valids = 0, drops = 0;
  bit  want_pairs = 0, lock_q = 0;

  function automatic logic [W-1:0] seqw(input int idx, input logic [W-1:0] prv);
    logic [W-1:0] v;
    v = W'(idx * 40503 + 4660) ^ W'(idx << 7);
    if (v == prv) v = v ^ 16'h0011;
    if (v == '1 || v == '0 || v == CVAL || v == ~CVAL) v = v ^ 16'h0101;
    return v;
  endfunction

  function automatic logic [W-1:0] specw(input int idx);
    int j;
    j = idx % 18;
    if (j == 0) return '0;
    if (j == 1) return '1;
    return W'(1) << (j - 2);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(tx_take_o == 1'b1 && tx_line_o == '0, "R10 tx reset", {15'd0, tx_take_o, tx_line_o}, {16'd1, 16'd0});
      chk(rx_data_o == '0 && !rx_valid_o && !rx_lock_o && !rx_err_o, "R10 rx reset",
          {rx_data_o, 13'd0, rx_valid_o, rx_lock_o, rx_err_o}, 32'd0);
    end else begin
      automatic int lat = dly ? 3 : 2;
      chk(tx_take_o == ((n % 2) == 0), "R2 take phase", {31'd0, tx_take_o}, {31'd0, (n % 2) == 0});
      if (took[n % M])
        chk(tx_line_o == w[n % M], "R1 true slot", {16'd0, tx_line_o}, {16'd0, w[n % M]});
      if (n >= 1 && took[(n - 1) % M])
        chk(tx_line_o == ~w[(n - 1) % M], "R1 inverted slot", {16'd0, tx_line_o}, {16'd0, ~w[(n - 1) % M]});
      if (n >= lat && took[(n - lat) % M]) pairs++;
      if (rx_valid_o && !rx_err_o)
        chk(n >= lat && took[(n - lat) % M] && rx_data_o == w[(n - lat) % M], "R7 payload",
            {16'd0, rx_data_o}, {16'd0, w[(n - lat) % M]});
      if (!rx_lock_o)
        chk(!rx_valid_o && rx_data_o == '0, "R9 unlocked output", {15'd0, rx_valid_o, rx_data_o}, 32'd0);
      if (rx_err_o) errs++;
      if (rx_valid_o) valids++;
      if (rx_lock_o && !lock_q && want_pairs) begin
        chk(pairs == 8, "R3 pairs at lock", pairs, 8);
        want_pairs = 0;
      end
      if (!rx_lock_o && lock_q) begin
        drops++;
        chk(rx_err_o, "R6 loss with error pulse", {31'd0, rx_err_o}, 1);
      end
      lock_q = rx_lock_o;
      // drive next cycle
      took[(n + 1) % M] = 0;
      if (tx_take_o) begin
        case (gen_mode)
          1:       tx_data_i = 16'h1234;
          2:       tx_data_i = specw(k);
          default: tx_data_i = seqw(k, lastw);
        endcase
        lastw = tx_data_i;
        w[(n + 1) % M] = tx_data_i;
        took[(n + 1) % M] = 1;
        k++;
      end
      if (cmode) rx_line_i = cword;
      else       rx_line_i = (dly ? hold : tx_line_o) ^ mask;
      mask = '0;
      hold = tx_line_o;
      n++;
    end
  end

  task automatic ticks(input int c);
    repeat (c) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input bit d, input int g, input bit cm, input logic [W-1:0] cv);
    rst_n = 1'b0;
    dly = d; gen_mode = g; cmode = cm; cword = cv;
    for (int i = 0; i < M; i++) took[i] = 0;
    n = 0; k = 0; pairs = 0; errs = 0; valids = 0; drops = 0;
    hold = '0; lastw = '0; lock_q = 0; mask = '0;
    ticks(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    // Direct loopback, changing payload
    do_reset(0, 0, 0, CVAL);
    want_pairs = 1;
    ticks(40);
    chk(rx_lock_o, "R3 lock direct", {31'd0, rx_lock_o}, 1);
    valids = 0;
    ticks(40);
    chk(valids == 20, "R7 strobe rate", valids, 20);
    // Degenerate payload words
    gen_mode = 2; e0 = errs;
    ticks(60);
    chk(errs == e0 && rx_lock_o, "R8 special words no error", errs, e0);
    gen_mode = 0;
    ticks(6);
    // Single flipped bit
    e0 = errs; mask = 16'h0004;
    ticks(10);
    chk(errs == e0 + 1, "R5 single error pulse", errs, e0 + 1);
    chk(rx_lock_o, "R5 lock kept after one error", {31'd0, rx_lock_o}, 1);
    // Three failed pairs
    e0 = errs; cmode = 1;
    ticks(5);
    cmode = 0;
    ticks(10);
    chk(errs == e0 + 3, "R5 three errors", errs, e0 + 3);
    chk(rx_lock_o, "R5 lock kept after three errors", {31'd0, rx_lock_o}, 1);
    // Four failed pairs
    e0 = errs; drops = 0; cmode = 1;
    ticks(7);
    cmode = 0;
    ticks(3);
    chk(errs == e0 + 4, "R6 four errors", errs, e0 + 4);
    chk(drops == 1 && !rx_lock_o, "R6 lock dropped", drops, 1);
    ticks(40);
    chk(rx_lock_o, "R6 relock", {31'd0, rx_lock_o}, 1);
    // Stream shifted by one line word
    do_reset(1, 0, 0, CVAL);
    want_pairs = 1;
    ticks(40);
    chk(rx_lock_o, "R3 lock shifted", {31'd0, rx_lock_o}, 1);
    valids = 0;
    ticks(40);
    chk(valids == 20, "R7 strobe rate shifted", valids, 20);
    // Idle constant lines
    do_reset(0, 0, 1, 16'h0000);
    ticks(100);
    chk(!rx_lock_o && drops == 0, "R4 idle zero line", {31'd0, rx_lock_o}, 0);
    do_reset(0, 0, 1, 16'hFFFF);
    ticks(100);
    chk(!rx_lock_o, "R4 idle ones line", {31'd0, rx_lock_o}, 0);
    // Repeated fixed payload
    do_reset(0, 1, 0, CVAL);
    ticks(100);
    chk(!rx_lock_o, "R4 repeated payload", {31'd0, rx_lock_o}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule